// File: doc/BRIEF.md
# Double-to-Single Narrowing Converter

This block takes a 64-bit double-precision operand and produces the nearest value a single-precision number can hold, still written in double format. The operand is first sorted into one of seven classes by its biased exponent and fraction. The class decides the path. Values in single range are rounded to a 24-bit significand. Values too small for a single normal number are shifted right one bit per clock until they reach the smallest single exponent, and are then rounded. Values too large become signed infinity. Zeros, infinities and NaNs take a fixed path.

Operands enter on a valid/ready handshake. The unit holds one operand at a time. It signals completion with a one-cycle done pulse and keeps the class code and the result on its outputs until the next completion. Rounding always uses round-to-nearest, ties to even.

Top module: `d2s_convert`

## Requirements
- R1: The class code is 0 for zero (bits 62..0 clear) and 1 for normal (biased exponent 897 to 1150). It is 2 for underflow (exponent below 897 with a nonzero magnitude) and 3 for overflow (exponent 1151 to 2046). It is 4 for infinity (exponent 2047, fraction zero), 5 for a quiet NaN (exponent 2047, bit 51 set) and 6 for a signalling NaN (exponent 2047, bit 51 clear, fraction nonzero).
- R2: A normal operand is rounded to a 24-bit significand with round-to-nearest, ties to even. The guard bit is fraction bit 28, the round bit is bit 27, and bits 26..0 are sticky. Done rises at the first clock edge after the accepting edge.
- R3: When rounding carries out of the significand, the exponent goes up by one. If that exponent exceeds 127 unbiased, the result is signed infinity.
- R4: An overflow-class operand gives signed infinity: exponent field 2047 and fraction zero.
- R5: A zero operand gives a result with the operand's sign and all other bits zero.
- R6: An infinity or a quiet NaN is passed through unchanged. A signalling NaN is passed through with bit 51 set.
- R7: An underflow operand is shifted right one bit per clock, and its exponent goes up by one each time, until the exponent reaches -126. An exponent field of 0 counts as -1022. Done rises n+1 edges after acceptance, where n is the number of shifts.
- R8: After the shifts, bits shifted out feed guard, then round, then the sticky OR, and the value is rounded to nearest even at exponent -126. A nonzero result is renormalised into double format. A zero significand gives a signed zero.
- R9: in_ready is low from the edge that accepts an operand until done. An operand offered while in_ready is low has no effect on the result in flight.
- R10: Done lasts exactly one cycle. The class code and result hold their values between done pulses. After reset, done is low, in_ready is high and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_operand | input | 64 | Double-precision operand |
| out_done | output | 1 | One-cycle completion pulse |
| out_class | output | 3 | Class code of the last operand (R1 encoding) |
| out_result | output | 64 | Single-precision-rounded value in double format |

## Verification
A wrong exponent or wrong guard, round or sticky bits in the shift register show at the ports as a done pulse that comes too early or too late. They can also show as a result one unit in the last place off, or as a zero where the smallest subnormal should appear. The bench therefore checks the exact done latency as well as every result bit. A stuck control state shows on in_ready or out_done within one cycle of acceptance. The cases straddle every class boundary: exponent 896/897, exponent 1150/1151, the halfway ties, the carry into the next exponent and the carry into the smallest single normal.

// File: rtl/d2s_pkg.sv
// Shared widths, limits and the class encoding for the narrowing converter.
// Assumes an IEEE double-precision source and a single-precision target.
package d2s_pkg;
    localparam int DBL_W     = 64;
    localparam int EXP_W     = 11;
    localparam int FRAC_W    = 52;
    localparam int SIG_W     = FRAC_W + 1;
    localparam int BIAS      = 1023;
    localparam int EXP_ALL1  = (1 << EXP_W) - 1;
    localparam int TGT_MANT  = 24;
    localparam int TGT_EMIN  = -126;
    localparam int TGT_EMAX  = 127;
    localparam int LOW_FIELD = TGT_EMIN + BIAS;
    localparam int HIGH_FIELD = TGT_EMAX + BIAS;
    localparam int EXPI_W    = EXP_W + 2;
    localparam int LZ_W      = $clog2(TGT_MANT);
    localparam int GUARD_POS = SIG_W - TGT_MANT - 1;
    localparam int QUIET_BIT = FRAC_W - 1;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_NORMAL = 3'd1,
        CLS_UNDER  = 3'd2,
        CLS_OVER   = 3'd3,
        CLS_INF    = 3'd4,
        CLS_QNAN   = 3'd5,
        CLS_SNAN   = 3'd6
    } opclass_e;
endpackage

// File: rtl/d2s_classify.sv
// Combinational classifier: sorts a double operand against single-precision
// limits and unpacks its unbiased exponent and 53-bit significand.
// Assumes nothing about the operand; every bit pattern gets a class.
module d2s_classify
    import d2s_pkg::*;
(
    input  logic [DBL_W-1:0]         operand,
    output opclass_e                 cls,
    output logic signed [EXPI_W-1:0] exp_o,
    output logic [SIG_W-1:0]         sig_o
);
    logic [EXP_W-1:0]         field;
    logic [FRAC_W-1:0]        frac;
    logic                     mag_nz;
    logic signed [EXPI_W-1:0] field_s;

    assign field   = operand[DBL_W-2 -: EXP_W];
    assign frac    = operand[FRAC_W-1:0];
    assign mag_nz  = |operand[DBL_W-2:0];
    assign field_s = signed'({{(EXPI_W-EXP_W){1'b0}}, field});

    // Class decision, ordered so each range test stands on its own.
    always_comb begin
        if (!mag_nz)
            cls = CLS_ZERO;
        else if (32'(field) < LOW_FIELD)
            cls = CLS_UNDER;
        else if (32'(field) <= HIGH_FIELD)
            cls = CLS_NORMAL;
        else if (32'(field) < EXP_ALL1)
            cls = CLS_OVER;
        else if (frac == '0)
            cls = CLS_INF;
        else if (frac[QUIET_BIT])
            cls = CLS_QNAN;
        else
            cls = CLS_SNAN;
    end

    // Unbiased exponent and significand with the hidden bit made explicit.
    always_comb begin
        if (field == '0) begin
            exp_o = EXPI_W'(1 - BIAS);
            sig_o = {1'b0, frac};
        end else begin
            exp_o = field_s - EXPI_W'(BIAS);
            sig_o = {1'b1, frac};
        end
    end
endmodule

// File: rtl/d2s_denorm.sv
// Iterative denormaliser: holds exponent and significand, and on each step
// shifts the significand right by one while raising the exponent, feeding
// the lost bit into guard, guard into round, and round into sticky.
// Assumes load and step are never both high.
module d2s_denorm
    import d2s_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic signed [EXPI_W-1:0] exp_i,
    input  logic [SIG_W-1:0]         sig_i,
    output logic signed [EXPI_W-1:0] exp_q,
    output logic [SIG_W-1:0]         sig_q,
    output logic                     g_q,
    output logic                     r_q,
    output logic                     x_q,
    output logic                     at_floor
);
    // Floor reached once the exponent equals the smallest single exponent.
    assign at_floor = (exp_q >= EXPI_W'(TGT_EMIN));

    // Load a fresh operand or take one shift step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            sig_q <= '0;
            g_q   <= 1'b0;
            r_q   <= 1'b0;
            x_q   <= 1'b0;
        end else if (load) begin
            exp_q <= exp_i;
            sig_q <= sig_i;
            g_q   <= 1'b0;
            r_q   <= 1'b0;
            x_q   <= 1'b0;
        end else if (step) begin
            exp_q <= exp_q + EXPI_W'(1);
            sig_q <= {1'b0, sig_q[SIG_W-1:1]};
            g_q   <= sig_q[0];
            r_q   <= g_q;
            x_q   <= x_q | r_q;
        end
    end
endmodule

// File: rtl/d2s_round_pack.sv
// Combinational round-to-nearest-even on a 24-bit significand, followed by
// renormalisation and packing into double format; special classes take a
// fixed result. Assumes exp/sig already sit at or above the single floor.
module d2s_round_pack
    import d2s_pkg::*;
(
    input  opclass_e                 cls,
    input  logic [DBL_W-1:0]         operand,
    input  logic signed [EXPI_W-1:0] exp_i,
    input  logic [SIG_W-1:0]         sig_i,
    input  logic                     g_i,
    input  logic                     r_i,
    input  logic                     x_i,
    output logic [DBL_W-1:0]         result
);
    logic                     sign;
    logic [TGT_MANT-1:0]      mant;
    logic                     gb, rb, xb, inc;
    logic [TGT_MANT:0]        sum;
    logic [TGT_MANT-1:0]      mant_r;
    logic signed [EXPI_W-1:0] exp_r;
    logic [LZ_W-1:0]          lz;
    logic [TGT_MANT-1:0]      norm;
    logic signed [EXPI_W-1:0] exp_n;
    logic [EXPI_W-1:0]        field_w;
    logic [DBL_W-1:0]         inf_res;
    logic [DBL_W-1:0]         zero_res;

    assign sign     = operand[DBL_W-1];
    assign mant     = sig_i[SIG_W-1 -: TGT_MANT];
    assign gb       = sig_i[GUARD_POS];
    assign rb       = sig_i[GUARD_POS-1];
    assign xb       = (|sig_i[GUARD_POS-2:0]) | g_i | r_i | x_i;
    assign inc      = gb & (mant[0] | rb | xb);
    assign sum      = {1'b0, mant} + {{TGT_MANT{1'b0}}, inc};
    assign inf_res  = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    assign zero_res = {sign, {(DBL_W-1){1'b0}}};

    // Carry out of the significand moves the value up one binade.
    always_comb begin
        if (sum[TGT_MANT]) begin
            mant_r = {1'b1, {(TGT_MANT-1){1'b0}}};
            exp_r  = exp_i + EXPI_W'(1);
        end else begin
            mant_r = sum[TGT_MANT-1:0];
            exp_r  = exp_i;
        end
    end

    // Leading-zero count of the rounded significand for renormalisation.
    always_comb begin
        lz = '0;
        for (int i = 0; i < TGT_MANT; i++) begin
            if (mant_r[i]) lz = LZ_W'(TGT_MANT - 1 - i);
        end
    end

    assign norm    = mant_r << lz;
    assign exp_n   = exp_r - EXPI_W'(lz);
    assign field_w = EXPI_W'(exp_n + EXPI_W'(BIAS));

    // Result selection by class.
    always_comb begin
        unique case (cls)
            CLS_ZERO: result = zero_res;
            CLS_OVER: result = inf_res;
            CLS_INF,
            CLS_QNAN: result = operand;
            CLS_SNAN: result = operand | (DBL_W'(1) << QUIET_BIT);
            default: begin
                if (mant_r == '0)
                    result = zero_res;
                else if (exp_n > EXPI_W'(TGT_EMAX))
                    result = inf_res;
                else
                    result = {sign, field_w[EXP_W-1:0], norm[TGT_MANT-2:0],
                              {(FRAC_W-TGT_MANT+1){1'b0}}};
            end
        endcase
    end
endmodule

// File: rtl/d2s_convert.sv
// Top of the double-to-single narrowing converter. Accepts one operand on a
// valid/ready handshake, classifies it, denormalises underflow operands one
// bit per clock, rounds to nearest even and emits a one-cycle done pulse
// with a held class code and result. Assumes a single clock domain.
module d2s_convert
    import d2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DBL_W-1:0] in_operand,
    output logic             out_done,
    output logic [2:0]       out_class,
    output logic [DBL_W-1:0] out_result
);
    typedef enum logic {ST_IDLE, ST_BUSY} state_e;

    state_e                   state;
    opclass_e                 cls_c;
    opclass_e                 cls_q;
    logic [DBL_W-1:0]         op_q;
    logic signed [EXPI_W-1:0] exp_c;
    logic [SIG_W-1:0]         sig_c;
    logic signed [EXPI_W-1:0] exp_q;
    logic [SIG_W-1:0]         sig_q;
    logic                     g_q, r_q, x_q, at_floor;
    logic                     accept, finish, step;
    logic [DBL_W-1:0]         result_c;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid & in_ready;
    assign finish   = (state == ST_BUSY) & ((cls_q != CLS_UNDER) | at_floor);
    assign step     = (state == ST_BUSY) & ~finish;

    d2s_classify u_classify (
        .operand (in_operand),
        .cls     (cls_c),
        .exp_o   (exp_c),
        .sig_o   (sig_c)
    );

    d2s_denorm u_denorm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (step),
        .exp_i    (exp_c),
        .sig_i    (sig_c),
        .exp_q    (exp_q),
        .sig_q    (sig_q),
        .g_q      (g_q),
        .r_q      (r_q),
        .x_q      (x_q),
        .at_floor (at_floor)
    );

    d2s_round_pack u_round (
        .cls     (cls_q),
        .operand (op_q),
        .exp_i   (exp_q),
        .sig_i   (sig_q),
        .g_i     (g_q),
        .r_i     (r_q),
        .x_i     (x_q),
        .result  (result_c)
    );

    // Control: idle until accept, busy until the operand is finished.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (accept) state <= ST_BUSY;
        else if (finish) state <= ST_IDLE;
    end

    // Capture class and raw operand at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= CLS_ZERO;
            op_q  <= '0;
        end else if (accept) begin
            cls_q <= cls_c;
            op_q  <= in_operand;
        end
    end

    // Output registers: pulse done and hold class/result until next finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done   <= 1'b0;
            out_class  <= 3'd0;
            out_result <= '0;
        end else begin
            out_done <= finish;
            if (finish) begin
                out_class  <= cls_q;
                out_result <= result_c;
            end
        end
    end
endmodule

// File: rtl/d2s_convert_chk.sv
// Property checker for d2s_convert, attached by bind. Observes ports only.
module d2s_convert_chk
    import d2s_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_done,
    input logic [2:0]       out_class,
    input logic [DBL_W-1:0] out_result
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> ($stable(out_result) && $stable(out_class)));

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> in_ready);

    a_r5_zero_sign_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_class == 3'(CLS_ZERO)) |-> (out_result[DBL_W-2:0] == '0));

    a_r4_over_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_class == 3'(CLS_OVER)) |->
        (out_result[DBL_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    a_r6_snan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_class == 3'(CLS_SNAN)) |->
        (out_result[DBL_W-2:QUIET_BIT] == {(EXP_W+1){1'b1}}));

    a_r8_under_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_class == 3'(CLS_UNDER)) |->
        (32'(out_result[DBL_W-2 -: EXP_W]) <= LOW_FIELD));
endmodule

bind d2s_convert d2s_convert_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_done   (out_done),
    .out_class  (out_class),
    .out_result (out_result)
);

// File: tb/d2s_convert_tb.sv
module d2s_convert_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_operand = '0;
    logic        out_done;
    logic [2:0]  out_class;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    d2s_convert u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_operand (in_operand),
        .out_done   (out_done),
        .out_class  (out_class),
        .out_result (out_result)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Offer one operand, wait for done, check result, class, latency, pulse.
    task automatic run_case(input logic [63:0] op, input logic [63:0] exp_res,
                            input logic [2:0] exp_cls, input int exp_lat,
                            input string tag, input bit poke);
        int lat;
        @(negedge clk);
        chk(in_ready === 1'b1, "R9", "ready before offer", 64'(in_ready), 64'd1);
        in_operand = op;
        in_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (poke) in_operand = 64'h3FF0000000000000;
        else      in_valid = 1'b0;
        chk(in_ready === 1'b0, "R9", "ready after accept", 64'(in_ready), 64'd0);
        lat = 0;
        do begin
            if (lat == 3) in_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end while (out_done !== 1'b1 && lat < 2000);
        in_valid = 1'b0;
        chk(lat == exp_lat, tag, "done latency", 64'(lat), 64'(exp_lat));
        chk(out_result === exp_res, tag, "result", out_result, exp_res);
        chk(out_class === exp_cls, "R1", "class", 64'(out_class), 64'(exp_cls));
        @(posedge clk);
        @(negedge clk);
        chk(out_done === 1'b0, "R10", "done pulse width", 64'(out_done), 64'd0);
        chk(out_result === exp_res, "R10", "result held", out_result, exp_res);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_done === 1'b0, "R10", "reset done", 64'(out_done), 64'd0);
        chk(in_ready === 1'b1, "R10", "reset ready", 64'(in_ready), 64'd1);
        chk(out_result === 64'd0, "R10", "reset result", out_result, 64'd0);
    endtask

    task automatic t_normal_rounding();
        run_case(64'h3FF0000000000000, 64'h3FF0000000000000, 3'd1, 1, "R2 exact", 0);
        run_case(64'h3FF0000000000001, 64'h3FF0000000000000, 3'd1, 1, "R2 sticky only", 0);
        run_case(64'h3FF0000010000001, 64'h3FF0000020000000, 3'd1, 1, "R2 above half", 0);
        run_case(64'h3FF0000010000000, 64'h3FF0000000000000, 3'd1, 1, "R2 tie even down", 0);
        run_case(64'h3FF0000030000000, 64'h3FF0000040000000, 3'd1, 1, "R2 tie odd up", 0);
        run_case(64'hBFF0000030000000, 64'hBFF0000040000000, 3'd1, 1, "R2 negative tie", 0);
        run_case(64'h3FFFFFFFF0000000, 64'h4000000000000000, 3'd1, 1, "R3 carry", 0);
        run_case(64'h47EFFFFFF0000000, 64'h7FF0000000000000, 3'd1, 1, "R3 carry to inf", 0);
    endtask

    task automatic t_boundaries();
        run_case(64'h3810000000000000, 64'h3810000000000000, 3'd1, 1, "R1 low edge", 0);
        run_case(64'h47E0000000000000, 64'h47E0000000000000, 3'd1, 1, "R1 high edge", 0);
        run_case(64'h47F0000000000000, 64'h7FF0000000000000, 3'd3, 1, "R4 over pos", 0);
        run_case(64'hC7F0000000000000, 64'hFFF0000000000000, 3'd3, 1, "R4 over neg", 0);
    endtask

    task automatic t_special();
        run_case(64'h0000000000000000, 64'h0000000000000000, 3'd0, 1, "R5 +zero", 0);
        run_case(64'h8000000000000000, 64'h8000000000000000, 3'd0, 1, "R5 -zero", 0);
        run_case(64'h7FF0000000000000, 64'h7FF0000000000000, 3'd4, 1, "R6 inf", 0);
        run_case(64'h7FF8000000000001, 64'h7FF8000000000001, 3'd5, 1, "R6 qnan", 0);
        run_case(64'hFFF0000000000001, 64'hFFF8000000000001, 3'd6, 1, "R6 snan", 0);
    endtask

    task automatic t_underflow();
        run_case(64'h3800000000000000, 64'h3800000000000000, 3'd2, 2, "R7 one shift", 0);
        run_case(64'h36A0000000000000, 64'h36A0000000000000, 3'd2, 24, "R7 min subnormal", 0);
        run_case(64'h3690000000000000, 64'h0000000000000000, 3'd2, 25, "R8 tie to zero", 0);
        run_case(64'h3698000000000000, 64'h36A0000000000000, 3'd2, 25, "R8 round up", 0);
        run_case(64'h380FFFFFF0000000, 64'h3810000000000000, 3'd2, 2, "R8 to min normal", 0);
        run_case(64'h8000000000000001, 64'h8000000000000000, 3'd2, 897, "R7 field zero", 0);
    endtask

    task automatic t_busy_ignore();
        run_case(64'h36A0000000000000, 64'h36A0000000000000, 3'd2, 24, "R9 busy offer ignored", 1);
    endtask

    initial begin
        t_reset();
        t_normal_rounding();
        t_boundaries();
        t_special();
        t_underflow();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule